// File: doc/BRIEF.md
# Microcoded Accumulator CPU Core

An 8-bit accumulator processor with its own 256-word by 8-bit program and data store. Every instruction passes through a register-transfer sequence. The program counter goes into the memory address register, and the store's registered read output lands in the memory data register. The opcode byte is then decoded and, when the instruction needs one, a second byte is fetched in the same way. The working registers are the accumulator, a general register, a stack pointer and a single condition flag. The condition flag is written only by the two explicit zero-test instructions.

The core runs while `run` is high and freezes completely while it is low. After a halt instruction it stays halted until the next reset. The accumulator is always visible on `acc_out` so that it can be shown on an external display. The store is an internal synchronous array. A test environment fills it while reset is held.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is held and directly after it is released, `acc_out` is 0x00 and `halted` is 0. Reset clears the program counter, accumulator, general register, stack pointer and flag, so execution starts at address 0x00.
- R2: Opcode 0x20 followed by an address byte copies that memory word into the accumulator. Opcode 0x30 followed by an address byte writes the accumulator into that word.
- R3: Opcode 0x40 copies the accumulator into the general register. Opcode 0x50 replaces the accumulator with the sum of the accumulator and the general register, modulo 256, with no carry kept.
- R4: Opcode 0x60 replaces the accumulator with the bitwise AND of the accumulator and the general register.
- R5: Opcode 0x70 sets the flag when the accumulator is zero and clears it otherwise. Opcode 0x71 does the opposite. The full opcode byte is compared, so the two are always told apart.
- R6: Opcode 0x80 followed by a target byte continues execution at that target.
- R7: Opcode 0x90 followed by a target byte continues at the target when the flag is 1. When the flag is 0, execution continues at the byte after the target.
- R8: No instruction other than 0x70 and 0x71 changes the flag. In particular, an addition with a zero result does not.
- R9: Opcode 0xC0 followed by a value byte loads the stack pointer. Opcode 0xD0 first decrements the stack pointer and then stores the accumulator at the new pointer. Opcode 0xE0 loads the accumulator from the word at the pointer and then increments the pointer. The pointer wraps modulo 256, so a push straight after reset writes address 0xFF.
- R10: Opcode 0xF0 raises `halted`. From then until reset, `halted` stays 1 and `acc_out` does not change, whatever `run` does.
- R11: While `run` is low, no register or memory word changes. Execution resumes where it stopped once `run` returns high.
- R12: Every opcode byte not listed above is a single-byte no-op. It leaves the accumulator unchanged and does not consume the following byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Lets the sequencer advance while high |
| halted | output | 1 | High once a halt instruction has executed |
| acc_out | output | 8 | Current accumulator value |

## Verification
The flag has no port of its own, so its value can only be seen through the path a conditional jump takes. Each branch scenario first sets up the accumulator with a load, then runs one of the two zero tests, and then jumps conditionally. The two possible landing points load different marker values, so the final accumulator shows which way the jump went. Flag preservation across an addition is checked the same way: a sum of 0xFF and 0x01 gives zero, and the following jump must not be taken. Stack order and the address used by the pre-decrement are checked by loading the pushed words back directly by address.

// File: rtl/acc_cpu_pkg.sv
`timescale 1ns/1ps
package acc_cpu_pkg;

    localparam int WORD_W = 8;
    localparam int DEPTH  = 1 << WORD_W;

    localparam logic [7:0] OPC_LOAD   = 8'h20;
    localparam logic [7:0] OPC_STORE  = 8'h30;
    localparam logic [7:0] OPC_MOVE   = 8'h40;
    localparam logic [7:0] OPC_ADD    = 8'h50;
    localparam logic [7:0] OPC_AND    = 8'h60;
    localparam logic [7:0] OPC_TESTNZ = 8'h70;
    localparam logic [7:0] OPC_TESTZ  = 8'h71;
    localparam logic [7:0] OPC_JUMP   = 8'h80;
    localparam logic [7:0] OPC_JUMPZ  = 8'h90;
    localparam logic [7:0] OPC_LDSP   = 8'hC0;
    localparam logic [7:0] OPC_PUSH   = 8'hD0;
    localparam logic [7:0] OPC_POP    = 8'hE0;
    localparam logic [7:0] OPC_HALT   = 8'hF0;

    typedef enum logic [3:0] {
        K_NOP, K_LOAD, K_STORE, K_MOVE, K_ADD, K_AND, K_TESTNZ,
        K_TESTZ, K_JUMP, K_JUMPZ, K_LDSP, K_PUSH, K_POP, K_HALT
    } kind_e;

    typedef struct packed {
        kind_e kind;
        logic  two_byte;
    } dec_t;

    typedef enum logic [3:0] {
        ST_FADDR, ST_FREAD, ST_FLATCH, ST_DECODE,
        ST_OADDR, ST_OREAD, ST_OLATCH, ST_EXEC,
        ST_RDWAIT, ST_RDLATCH, ST_WBACK,
        ST_PUSHSET, ST_WRITE, ST_HALT
    } state_e;

    typedef struct packed {
        state_e              st;
        kind_e               kind;
        logic [WORD_W-1:0]   pc;
        logic [WORD_W-1:0]   mar;
        logic [WORD_W-1:0]   mdr;
        logic [WORD_W-1:0]   a;
        logic [WORD_W-1:0]   r;
        logic [WORD_W-1:0]   sp;
        logic                z;
    } cpu_regs_t;

endpackage

// File: rtl/acc_cpu_decode.sv
`timescale 1ns/1ps
module acc_cpu_decode
    import acc_cpu_pkg::*;
(
    input  logic [7:0] opcode,
    output dec_t       dec
);
    always_comb begin
        dec.two_byte = 1'b0;
        unique case (opcode)
            OPC_LOAD:   begin dec.kind = K_LOAD;   dec.two_byte = 1'b1; end
            OPC_STORE:  begin dec.kind = K_STORE;  dec.two_byte = 1'b1; end
            OPC_MOVE:         dec.kind = K_MOVE;
            OPC_ADD:          dec.kind = K_ADD;
            OPC_AND:          dec.kind = K_AND;
            OPC_TESTNZ:       dec.kind = K_TESTNZ;
            OPC_TESTZ:        dec.kind = K_TESTZ;
            OPC_JUMP:   begin dec.kind = K_JUMP;   dec.two_byte = 1'b1; end
            OPC_JUMPZ:  begin dec.kind = K_JUMPZ;  dec.two_byte = 1'b1; end
            OPC_LDSP:   begin dec.kind = K_LDSP;   dec.two_byte = 1'b1; end
            OPC_PUSH:         dec.kind = K_PUSH;
            OPC_POP:          dec.kind = K_POP;
            OPC_HALT:         dec.kind = K_HALT;
            default:          dec.kind = K_NOP;
        endcase
    end
endmodule

// File: rtl/acc_cpu_alu.sv
`timescale 1ns/1ps
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  kind_e          kind,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   r,
    output logic [W-1:0]   y,
    output logic           nonzero
);
    // Only AND selects the logic path; every other kind gets the sum.
    always_comb begin
        if (kind == K_AND) y = a & r;
        else               y = a + r;
        nonzero = |a;
    end
endmodule

// File: rtl/acc_cpu_mem.sv
`timescale 1ns/1ps
module acc_cpu_mem #(
    parameter int W     = 8,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];
    logic [W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
        rdata_q <= mem_q[addr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/acc_cpu_core.sv
`timescale 1ns/1ps
module acc_cpu_core
    import acc_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    output logic              halted,
    output logic [WORD_W-1:0] acc_out
);
    cpu_regs_t         q, d;
    dec_t              dec;
    logic [WORD_W-1:0] alu_y;
    logic              a_nonzero;
    logic [WORD_W-1:0] rdata;
    logic              mem_we;

    acc_cpu_decode u_dec (
        .opcode (q.mdr),
        .dec    (dec)
    );

    acc_cpu_alu #(.W(WORD_W)) u_alu (
        .kind    (q.kind),
        .a       (q.a),
        .r       (q.r),
        .y       (alu_y),
        .nonzero (a_nonzero)
    );

    acc_cpu_mem #(.W(WORD_W), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .addr  (q.mar),
        .wdata (q.mdr),
        .rdata (rdata)
    );

    always_comb begin
        d      = q;
        mem_we = 1'b0;
        if (run) begin
            unique case (q.st)
                ST_FADDR:  begin d.mar = q.pc;           d.st = ST_FREAD;  end
                ST_FREAD:  begin d.pc  = q.pc + 1'b1;    d.st = ST_FLATCH; end
                ST_FLATCH: begin d.mdr = rdata;          d.st = ST_DECODE; end
                ST_DECODE: begin
                    d.kind = dec.kind;
                    d.st   = dec.two_byte ? ST_OADDR : ST_EXEC;
                end
                ST_OADDR:  begin d.mar = q.pc;           d.st = ST_OREAD;  end
                ST_OREAD:  begin d.pc  = q.pc + 1'b1;    d.st = ST_OLATCH; end
                ST_OLATCH: begin d.mdr = rdata;          d.st = ST_EXEC;   end
                ST_EXEC: begin
                    d.st = ST_FADDR;
                    unique case (q.kind)
                        K_LOAD:   begin d.mar = q.mdr; d.st = ST_RDWAIT; end
                        K_STORE:  begin d.mar = q.mdr; d.mdr = q.a; d.st = ST_WRITE; end
                        K_MOVE:   d.r  = q.a;
                        K_ADD:    d.a  = alu_y;
                        K_AND:    d.a  = alu_y;
                        K_TESTNZ: d.z  = ~a_nonzero;
                        K_TESTZ:  d.z  = a_nonzero;
                        K_JUMP:   d.pc = q.mdr;
                        K_JUMPZ:  if (q.z) d.pc = q.mdr;
                        K_LDSP:   d.sp = q.mdr;
                        K_PUSH:   begin d.sp = q.sp - 1'b1; d.st = ST_PUSHSET; end
                        K_POP:    begin d.mar = q.sp; d.st = ST_RDWAIT; end
                        K_HALT:   begin d.pc = '0; d.st = ST_HALT; end
                        default:  ;
                    endcase
                end
                ST_RDWAIT:  d.st = ST_RDLATCH;
                ST_RDLATCH: begin d.mdr = rdata; d.st = ST_WBACK; end
                ST_WBACK: begin
                    d.a = q.mdr;
                    if (q.kind == K_POP) d.sp = q.sp + 1'b1;
                    d.st = ST_FADDR;
                end
                ST_PUSHSET: begin d.mar = q.sp; d.mdr = q.a; d.st = ST_WRITE; end
                ST_WRITE:   begin mem_we = 1'b1; d.st = ST_FADDR; end
                ST_HALT:    d.st = ST_HALT;
                default:    d.st = ST_FADDR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_FADDR;
            q.kind <= K_NOP;
            q.pc   <= '0;
            q.mar  <= '0;
            q.mdr  <= '0;
            q.a    <= '0;
            q.r    <= '0;
            q.sp   <= '0;
            q.z    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign halted  = (q.st == ST_HALT);
    assign acc_out = q.a;
endmodule

// File: rtl/acc_cpu_core_chk.sv
`timescale 1ns/1ps
module acc_cpu_core_chk
    import acc_cpu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              halted,
    input logic [WORD_W-1:0] acc_out,
    input kind_e             kind,
    input logic              z,
    input logic              mem_we
);
    // R10
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R10
    halt_acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(acc_out));

    // R11
    pause_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !halted) |=> ($stable(acc_out) && !halted));

    // R8
    flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(z) |-> ($past(kind) == K_TESTNZ || $past(kind) == K_TESTZ));

    // R2
    write_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (kind == K_STORE || kind == K_PUSH));
endmodule

bind acc_cpu_core acc_cpu_core_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .halted  (halted),
    .acc_out (acc_out),
    .kind    (q.kind),
    .z       (q.z),
    .mem_we  (mem_we)
);

// File: tb/acc_cpu_core_test.sv
`timescale 1ns/1ps
module acc_cpu_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic       halted;
    logic [7:0] acc_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    acc_cpu_core uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .halted  (halted),
        .acc_out (acc_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] addr, input logic [7:0] val);
        uut.u_mem.mem_q[addr] = val;
    endtask

    // Hold reset, stop the core and clear the whole store.
    task automatic boot();
        rst_n = 1'b0;
        run   = 1'b0;
        repeat (3) @(posedge clk);
        for (int i = 0; i < 256; i++) uut.u_mem.mem_q[i] = 8'h00;
    endtask

    task automatic go();
        @(negedge clk);
        rst_n = 1'b1;
        run   = 1'b1;
    endtask

    task automatic wait_halt(input string req);
        bit seen = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (halted) begin seen = 1'b1; break; end
        end
        check({req, " halted"}, {7'd0, seen}, 8'h01);
    endtask

    task automatic t_reset();
        boot();
        check("R1 acc in reset", acc_out, 8'h00);
        check("R1 halted in reset", {7'd0, halted}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 acc after reset", acc_out, 8'h00);
        check("R1 halted after reset", {7'd0, halted}, 8'h00);
    endtask

    task automatic t_load_store();
        boot();
        poke(8'h00, 8'h20); poke(8'h01, 8'h40);
        poke(8'h02, 8'h30); poke(8'h03, 8'h41);
        poke(8'h04, 8'h20); poke(8'h05, 8'h42);
        poke(8'h06, 8'h20); poke(8'h07, 8'h41);
        poke(8'h08, 8'hF0);
        poke(8'h40, 8'h5A);
        go();
        wait_halt("R2");
        check("R2 store then load", acc_out, 8'h5A);
    endtask

    task automatic t_arith(input logic [7:0] opc, input logic [7:0] x,
                           input logic [7:0] y, input logic [7:0] exp, input string req);
        boot();
        poke(8'h00, 8'h20); poke(8'h01, 8'h40);
        poke(8'h02, 8'h40);
        poke(8'h03, 8'h20); poke(8'h04, 8'h41);
        poke(8'h05, opc);
        poke(8'h06, 8'hF0);
        poke(8'h40, x); poke(8'h41, y);
        go();
        wait_halt(req);
        check(req, acc_out, exp);
    endtask

    // Flag set by a zero test, then a conditional jump to 0x20.
    task automatic t_branch(input logic [7:0] aval, input logic [7:0] test_op,
                            input logic [7:0] exp, input string req);
        boot();
        poke(8'h00, 8'h20); poke(8'h01, 8'h40);
        poke(8'h02, test_op);
        poke(8'h03, 8'h90); poke(8'h04, 8'h20);
        poke(8'h05, 8'h20); poke(8'h06, 8'h41);
        poke(8'h07, 8'hF0);
        poke(8'h20, 8'h20); poke(8'h21, 8'h42);
        poke(8'h22, 8'hF0);
        poke(8'h40, aval); poke(8'h41, 8'h11); poke(8'h42, 8'h22);
        go();
        wait_halt(req);
        check(req, acc_out, exp);
    endtask

    task automatic t_flag_kept();
        boot();
        poke(8'h00, 8'h20); poke(8'h01, 8'h40);
        poke(8'h02, 8'h70);
        poke(8'h03, 8'h20); poke(8'h04, 8'h43);
        poke(8'h05, 8'h40);
        poke(8'h06, 8'h20); poke(8'h07, 8'h44);
        poke(8'h08, 8'h50);
        poke(8'h09, 8'h90); poke(8'h0A, 8'h20);
        poke(8'h0B, 8'hF0);
        poke(8'h20, 8'h20); poke(8'h21, 8'h42);
        poke(8'h22, 8'hF0);
        poke(8'h40, 8'h33); poke(8'h42, 8'h22);
        poke(8'h43, 8'hFF); poke(8'h44, 8'h01);
        go();
        wait_halt("R8");
        check("R8 zero sum leaves flag clear", acc_out, 8'h00);
    endtask

    task automatic t_jump();
        boot();
        poke(8'h00, 8'h80); poke(8'h01, 8'h10);
        poke(8'h02, 8'h20); poke(8'h03, 8'h41);
        poke(8'h04, 8'hF0);
        poke(8'h10, 8'h20); poke(8'h11, 8'h42);
        poke(8'h12, 8'hF0);
        poke(8'h41, 8'h11); poke(8'h42, 8'h22);
        go();
        wait_halt("R6");
        check("R6 jump target", acc_out, 8'h22);
    endtask

    task automatic t_stack();
        boot();
        poke(8'h00, 8'hC0); poke(8'h01, 8'h80);
        poke(8'h02, 8'h20); poke(8'h03, 8'h40);
        poke(8'h04, 8'hD0);
        poke(8'h05, 8'h20); poke(8'h06, 8'h41);
        poke(8'h07, 8'hD0);
        poke(8'h08, 8'hE0);
        poke(8'h09, 8'h40);
        poke(8'h0A, 8'hE0);
        poke(8'h0B, 8'h50);
        poke(8'h0C, 8'h30); poke(8'h0D, 8'h50);
        poke(8'h0E, 8'h20); poke(8'h0F, 8'h7E);
        poke(8'h10, 8'h40);
        poke(8'h11, 8'h20); poke(8'h12, 8'h50);
        poke(8'h13, 8'h50);
        poke(8'h14, 8'hF0);
        poke(8'h40, 8'h11); poke(8'h41, 8'h22);
        go();
        wait_halt("R9");
        // pops give 0x22 then 0x11, sum 0x33; M[0x7E] holds 0x22
        check("R9 push/pop order and addresses", acc_out, 8'h55);
    endtask

    task automatic t_stack_wrap();
        boot();
        poke(8'h00, 8'h20); poke(8'h01, 8'h40);
        poke(8'h02, 8'hD0);
        poke(8'h03, 8'h20); poke(8'h04, 8'h42);
        poke(8'h05, 8'h20); poke(8'h06, 8'hFF);
        poke(8'h07, 8'hF0);
        poke(8'h40, 8'h5C);
        go();
        wait_halt("R9");
        check("R9 push from reset writes 0xFF", acc_out, 8'h5C);
    endtask

    task automatic t_nop();
        boot();
        poke(8'h00, 8'h20); poke(8'h01, 8'h40);
        poke(8'h02, 8'h72);
        poke(8'h03, 8'h21);
        poke(8'h04, 8'h00);
        poke(8'h05, 8'hA5);
        poke(8'h06, 8'hF0);
        poke(8'h40, 8'h0F);
        go();
        wait_halt("R12");
        check("R12 unlisted opcodes", acc_out, 8'h0F);
    endtask

    task automatic t_halt_hold();
        logic [7:0] held;
        held = acc_out;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            run = (i % 3 != 0);
        end
        check("R10 halted kept", {7'd0, halted}, 8'h01);
        check("R10 acc kept after halt", acc_out, held);
        run = 1'b1;
    endtask

    task automatic t_pause();
        logic [7:0] held;
        boot();
        poke(8'h00, 8'h20); poke(8'h01, 8'h40);
        poke(8'h02, 8'h40);
        poke(8'h03, 8'h20); poke(8'h04, 8'h41);
        poke(8'h05, 8'h50);
        poke(8'h06, 8'hF0);
        poke(8'h40, 8'hF0); poke(8'h41, 8'h25);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (100) @(negedge clk);
        check("R11 idle acc", acc_out, 8'h00);
        check("R11 idle halted", {7'd0, halted}, 8'h00);
        run = 1'b1;
        repeat (16) @(negedge clk);
        run = 1'b0;
        held = acc_out;
        repeat (60) @(negedge clk);
        check("R11 paused acc", acc_out, held);
        check("R11 paused halted", {7'd0, halted}, 8'h00);
        run = 1'b1;
        wait_halt("R11");
        check("R11 resumed result", acc_out, 8'h15);
    endtask

    initial begin
        t_reset();
        t_load_store();
        t_arith(8'h50, 8'hF0, 8'h25, 8'h15, "R3 add wraps");
        t_arith(8'h50, 8'h12, 8'h34, 8'h46, "R3 add");
        t_arith(8'h60, 8'hCC, 8'hAA, 8'h88, "R4 and");
        t_branch(8'h00, 8'h70, 8'h22, "R5 R7 testnz zero taken");
        t_branch(8'h33, 8'h70, 8'h11, "R5 R7 testnz nonzero not taken");
        t_branch(8'h33, 8'h71, 8'h22, "R5 R7 testz nonzero taken");
        t_branch(8'h00, 8'h71, 8'h11, "R5 R7 testz zero not taken");
        t_flag_kept();
        t_jump();
        t_stack();
        t_stack_wrap();
        t_nop();
        t_halt_hold();
        t_pause();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule